// File: doc/BRIEF.md
# Capture/Compare Timer Unit

A 16-bit up-counter shared by a set of input-capture channels and a set of match-driven output pins. The counter advances either once every N+1 clock cycles from a programmable prescaler, or once per rising edge on an external event pin. A rising edge on a separate clear pin zeroes it. Each capture channel copies the current count into its own register when its pin shows a selected edge. Three compare values watch the counter: one drives pins high, one drives them low, and one flips a second class of pins. Every capture, every match and every counter wrap raises a sticky flag, and a flag is cleared by writing 1 to its bit.

All external pins pass through a two-flop synchroniser before any edge is detected. Configuration goes through a plain single-cycle register write port (`wr_en`, `wr_addr`, `wr_data`) that has no back-pressure. A write is accepted on every clock edge where `wr_en` is high. The block carries no data stream, so it has no valid/ready interface. Captured values, the count, the pins and the flags are plain outputs.

Register addresses: 0 control (bit 0 run, bit 1 external event source), 1 prescale, 2 capture edge select, 3 set-compare value, 4 reset-compare value, 5 toggle-compare value, 6 set/reset masks, 7 toggle mask, 8 flag clear, 9 count load.

Top module: `cct_timer_unit`

## Requirements
- R1: With control bit 0 = 1 and bit 1 = 0, the count rises by exactly one every PRESC+1 clock cycles, where PRESC is written at address 1. With control bit 0 = 0 the count holds.
- R2: With control bits 0 and 1 both set, the count rises by one for each rising edge on `evt_pin`. The prescaler plays no part in this mode.
- R3: An increment from 0xFFFF to 0x0000 sets the overflow flag, `flags_o` bit 7.
- R4: A rising edge on `clr_pin` sets the count to 0. While the pin stays high, the count goes on advancing.
- R5: At address 2, bit 2k enables capture on a rising edge of `cap_pin[k]` and bit 2k+1 enables it on a falling edge. An enabled edge copies the count into channel k of `cap_o`, bits 16k+15:16k, and sets `flags_o` bit k.
- R6: When an increment brings the count to the set-compare value, every pin 0..5 whose bit is set in address 6 bits 5:0 goes high, and `flags_o` bit 4 is set.
- R7: When an increment brings the count to the reset-compare value, every pin 0..5 whose bit is set in address 6 bits 13:8 goes low, and `flags_o` bit 5 is set. When both actions hit the same pin in one cycle, the pin goes low.
- R8: When an increment brings the count to the toggle-compare value, pin 6 flips if address 7 bit 6 is set and pin 7 flips if bit 7 is set. `flags_o` bit 6 is set.
- R9: Set and reset mask bits for pins 6..7 have no effect, and toggle mask bits for pins 0..5 have no effect.
- R10: A flag stays set until a write to address 8 has a 1 in that flag's bit. Bits written as 0 leave their flags unchanged.
- R11: After reset the count, the captures, the pins and the flags are all 0.
- R12: A write to address 9 loads the count. A loaded value equal to a compare value does not count as a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| evt_pin | input | 1 | External event input (asynchronous) |
| clr_pin | input | 1 | Counter clear input, rising edge (asynchronous) |
| cap_pin | input | 4 | Capture inputs (asynchronous) |
| count_o | output | 16 | Current count |
| cap_o | output | 64 | Captured counts, channel k in bits 16k+15:16k |
| pins_o | output | 8 | Compare pins: 0..5 set/reset class, 6..7 toggle class |
| flags_o | output | 8 | Sticky flags: 3:0 capture, 4 set, 5 reset, 6 toggle, 7 overflow |
| irq_o | output | 1 | OR of all flags |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, four capture channels, six set/reset pins, two toggle pins and an 8-bit prescaler. Loading the count through the register port puts the 0xFFFF wrap and each compare value one or two event edges away, so no long run is needed. Event-driven counting makes every match land on a known edge. A prescale of 3 checks the divide ratio over a fixed window, which holds whatever the phase of the prescaler.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_CTRL    = 4'd0;
  localparam logic [ADDR_W-1:0] A_PRESC   = 4'd1;
  localparam logic [ADDR_W-1:0] A_CAPCFG  = 4'd2;
  localparam logic [ADDR_W-1:0] A_CMP_SET = 4'd3;
  localparam logic [ADDR_W-1:0] A_CMP_RST = 4'd4;
  localparam logic [ADDR_W-1:0] A_CMP_TGL = 4'd5;
  localparam logic [ADDR_W-1:0] A_MASK_SR = 4'd6;
  localparam logic [ADDR_W-1:0] A_MASK_TG = 4'd7;
  localparam logic [ADDR_W-1:0] A_FLAGCLR = 4'd8;
  localparam logic [ADDR_W-1:0] A_COUNT   = 4'd9;
  // bit offset of the reset mask inside the set/reset mask register
  localparam int unsigned RST_MASK_OFS = 8;

  typedef struct packed {
    logic ext_src;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/cct_sync.sv
module cct_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prv
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      prv_q <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prv_q <= stg[STAGES-1];
    end
  end

  assign lvl = stg[STAGES-1];
  assign prv = prv_q;
endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ext_src,
  input  logic [PRE_W-1:0] presc,
  input  logic             ev_rise,
  input  logic             clr_rise,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt,
  output logic             adv,
  output logic             wrap
);
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick, inc;

  assign tick = run && (ext_src ? ev_rise : (pre_q >= presc));
  assign inc  = tick && !ld && !clr_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (!run || ext_src || clr_rise || (pre_q >= presc)) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      adv   <= 1'b0;
      wrap  <= 1'b0;
    end else begin
      adv  <= inc;
      wrap <= inc && (cnt_q == {CNT_W{1'b1}});
      if (ld)            cnt_q <= ld_val;
      else if (clr_rise) cnt_q <= '0;
      else if (inc)      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/cct_capture.sv
module cct_capture #(
  parameter int CNT_W = 16,
  parameter int N_CAP = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CNT_W-1:0]         cnt,
  input  logic [N_CAP-1:0]         lvl,
  input  logic [N_CAP-1:0]         prv,
  input  logic [2*N_CAP-1:0]       cfg,
  output logic [N_CAP-1:0]         evt,
  output logic [N_CAP*CNT_W-1:0]   cap
);
  for (genvar g = 0; g < N_CAP; g++) begin : g_ch
    logic             rise_e, fall_e;
    logic [CNT_W-1:0] val_q;

    assign rise_e = lvl[g] & ~prv[g] & cfg[2*g];
    assign fall_e = ~lvl[g] & prv[g] & cfg[2*g+1];
    assign evt[g] = rise_e | fall_e;

    always_ff @(posedge clk) begin
      if (!rst_n)      val_q <= '0;
      else if (evt[g]) val_q <= cnt;
    end

    assign cap[g*CNT_W +: CNT_W] = val_q;
  end
endmodule

// File: rtl/cct_compare.sv
module cct_compare #(
  parameter int CNT_W = 16,
  parameter int N_SR  = 6,
  parameter int N_TG  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     cnt,
  input  logic                 adv,
  input  logic [CNT_W-1:0]     cmp_set,
  input  logic [CNT_W-1:0]     cmp_rst,
  input  logic [CNT_W-1:0]     cmp_tgl,
  input  logic [N_SR-1:0]      msk_set,
  input  logic [N_SR-1:0]      msk_rst,
  input  logic [N_TG-1:0]      msk_tg,
  output logic [N_SR+N_TG-1:0] pins,
  output logic                 hit_set,
  output logic                 hit_rst,
  output logic                 hit_tgl
);
  // a match only counts on the cycle the counter has just stepped onto the value
  assign hit_set = adv && (cnt == cmp_set);
  assign hit_rst = adv && (cnt == cmp_rst);
  assign hit_tgl = adv && (cnt == cmp_tgl);

  for (genvar g = 0; g < N_SR; g++) begin : g_sr
    logic pin_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                    pin_q <= 1'b0;
      else if (hit_rst && msk_rst[g]) pin_q <= 1'b0;
      else if (hit_set && msk_set[g]) pin_q <= 1'b1;
    end
    assign pins[g] = pin_q;
  end

  for (genvar g = 0; g < N_TG; g++) begin : g_tg
    logic pin_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                    pin_q <= 1'b0;
      else if (hit_tgl && msk_tg[g]) pin_q <= ~pin_q;
    end
    assign pins[N_SR+g] = pin_q;
  end
endmodule

// File: rtl/cct_timer_unit.sv
module cct_timer_unit
  import cct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int N_CAP       = 4,
  parameter int N_SR        = 6,
  parameter int N_TG        = 2,
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [CNT_W-1:0]       wr_data,
  input  logic                   evt_pin,
  input  logic                   clr_pin,
  input  logic [N_CAP-1:0]       cap_pin,
  output logic [CNT_W-1:0]       count_o,
  output logic [N_CAP*CNT_W-1:0] cap_o,
  output logic [N_SR+N_TG-1:0]   pins_o,
  output logic [N_CAP+3:0]       flags_o,
  output logic                   irq_o
);
  localparam int NPIN   = N_SR + N_TG;
  localparam int FLAG_W = N_CAP + 4;

  ctrl_t              ctrl_q;
  logic [PRE_W-1:0]   presc_q;
  logic [2*N_CAP-1:0] capcfg_q;
  logic [CNT_W-1:0]   cmp_set_q, cmp_rst_q, cmp_tgl_q;
  logic [N_SR-1:0]    msk_set_q, msk_rst_q;
  logic [N_TG-1:0]    msk_tg_q;
  logic [FLAG_W-1:0]  flags_q;

  logic               ld_cnt, flag_wr;
  logic [N_CAP+1:0]   s_lvl, s_prv;
  logic               ev_rise, clr_rise;
  logic               adv, wrap;
  logic [CNT_W-1:0]   cnt;
  logic [N_CAP-1:0]   cap_evt;
  logic               hit_set, hit_rst, hit_tgl;

  assign ld_cnt  = wr_en && (wr_addr == A_COUNT);
  assign flag_wr = wr_en && (wr_addr == A_FLAGCLR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      presc_q   <= '0;
      capcfg_q  <= '0;
      cmp_set_q <= '0;
      cmp_rst_q <= '0;
      cmp_tgl_q <= '0;
      msk_set_q <= '0;
      msk_rst_q <= '0;
      msk_tg_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:    ctrl_q    <= ctrl_t'(wr_data[1:0]);
        A_PRESC:   presc_q   <= wr_data[PRE_W-1:0];
        A_CAPCFG:  capcfg_q  <= wr_data[2*N_CAP-1:0];
        A_CMP_SET: cmp_set_q <= wr_data;
        A_CMP_RST: cmp_rst_q <= wr_data;
        A_CMP_TGL: cmp_tgl_q <= wr_data;
        A_MASK_SR: begin
          msk_set_q <= wr_data[N_SR-1:0];
          msk_rst_q <= wr_data[RST_MASK_OFS +: N_SR];
        end
        A_MASK_TG: msk_tg_q  <= wr_data[NPIN-1:N_SR];
        default:   ;
      endcase
    end
  end

  cct_sync #(.W(N_CAP+2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({clr_pin, evt_pin, cap_pin}),
    .lvl  (s_lvl),
    .prv  (s_prv)
  );

  assign ev_rise  = s_lvl[N_CAP]   & ~s_prv[N_CAP];
  assign clr_rise = s_lvl[N_CAP+1] & ~s_prv[N_CAP+1];

  cct_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.run),
    .ext_src (ctrl_q.ext_src),
    .presc   (presc_q),
    .ev_rise (ev_rise),
    .clr_rise(clr_rise),
    .ld      (ld_cnt),
    .ld_val  (wr_data),
    .cnt     (cnt),
    .adv     (adv),
    .wrap    (wrap)
  );

  cct_capture #(.CNT_W(CNT_W), .N_CAP(N_CAP)) u_cap (
    .clk  (clk),
    .rst_n(rst_n),
    .cnt  (cnt),
    .lvl  (s_lvl[N_CAP-1:0]),
    .prv  (s_prv[N_CAP-1:0]),
    .cfg  (capcfg_q),
    .evt  (cap_evt),
    .cap  (cap_o)
  );

  cct_compare #(.CNT_W(CNT_W), .N_SR(N_SR), .N_TG(N_TG)) u_cmp (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt    (cnt),
    .adv    (adv),
    .cmp_set(cmp_set_q),
    .cmp_rst(cmp_rst_q),
    .cmp_tgl(cmp_tgl_q),
    .msk_set(msk_set_q),
    .msk_rst(msk_rst_q),
    .msk_tg (msk_tg_q),
    .pins   (pins_o),
    .hit_set(hit_set),
    .hit_rst(hit_rst),
    .hit_tgl(hit_tgl)
  );

  // a new event wins over a clear arriving in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else flags_q <= (flags_q & ~(flag_wr ? wr_data[FLAG_W-1:0] : '0))
                    | {wrap, hit_tgl, hit_rst, hit_set, cap_evt};
  end

  assign count_o = cnt;
  assign flags_o = flags_q;
  assign irq_o   = |flags_q;
endmodule

// File: rtl/cct_timer_chk.sv
module cct_timer_chk #(
  parameter int CNT_W = 16,
  parameter int N_CAP = 4,
  parameter int N_SR  = 6,
  parameter int N_TG  = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [CNT_W-1:0]       cnt,
  input logic                   cnt_load,
  input logic [N_SR+N_TG-1:0]   pins,
  input logic [N_CAP+3:0]       flags,
  input logic                   ovf_clr,
  input logic                   hit_rst,
  input logic                   hit_tgl,
  input logic [N_SR-1:0]        msk_rst,
  input logic [N_TG-1:0]        msk_tg,
  input logic [N_CAP-1:0]       cap_evt,
  input logic [N_CAP*CNT_W-1:0] cap_val,
  input logic                   wrap
);
  localparam int NPIN  = N_SR + N_TG;
  localparam int F_OVF = N_CAP + 3;

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == $past(cnt)) || (cnt == CNT_W'($past(cnt) + 1'b1)) || (cnt == '0) || $past(cnt_load));

  assert_overflow_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wrap) |-> flags[F_OVF]);

  for (genvar g = 0; g < N_CAP; g++) begin : g_cap
    assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cap_evt[g]) |-> (cap_val[g*CNT_W +: CNT_W] == $past(cnt)) && flags[g]);
  end

  assert_reset_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hit_rst) |-> ((pins[N_SR-1:0] & $past(msk_rst)) == '0));

  assert_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hit_tgl) |-> (pins[NPIN-1:N_SR] == ($past(pins[NPIN-1:N_SR]) ^ $past(msk_tg))));

  assert_toggle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hit_tgl) |-> $stable(pins[NPIN-1:N_SR]));

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flags[F_OVF]) && !$past(ovf_clr)) |-> flags[F_OVF]);
endmodule

bind cct_timer_unit cct_timer_chk #(
  .CNT_W(CNT_W), .N_CAP(N_CAP), .N_SR(N_SR), .N_TG(N_TG)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cnt     (count_o),
  .cnt_load(ld_cnt),
  .pins    (pins_o),
  .flags   (flags_o),
  .ovf_clr (flag_wr && wr_data[N_CAP+3]),
  .hit_rst (hit_rst),
  .hit_tgl (hit_tgl),
  .msk_rst (msk_rst_q),
  .msk_tg  (msk_tg_q),
  .cap_evt (cap_evt),
  .cap_val (cap_o),
  .wrap    (wrap)
);

// File: tb/tb_cct_timer_unit.sv
module tb_cct_timer_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        evt_pin = 1'b0;
  logic        clr_pin = 1'b0;
  logic [3:0]  cap_pin = '0;
  logic [15:0] count_o;
  logic [63:0] cap_o;
  logic [7:0]  pins_o;
  logic [7:0]  flags_o;
  logic        irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  cct_timer_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .evt_pin(evt_pin), .clr_pin(clr_pin), .cap_pin(cap_pin),
    .count_o(count_o), .cap_o(cap_o), .pins_o(pins_o), .flags_o(flags_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic epulse(input int n);
    for (int i = 0; i < n; i++) begin
      evt_pin = 1'b1; idle(4);
      evt_pin = 1'b0; idle(4);
    end
  endtask

  task automatic t_reset;
    chk("R11 count", count_o, 16'h0);
    chk("R11 captures", cap_o, 64'h0);
    chk("R11 pins", pins_o, 8'h0);
    chk("R11 flags", {irq_o, flags_o}, 9'h0);
  endtask

  task automatic t_prescale;
    logic [15:0] a;
    wr(4'd1, 16'd3);
    wr(4'd0, 16'h1);
    idle(3);
    a = count_o; idle(8);
    chk("R1 prescale 3", count_o - a, 16'd2);
    wr(4'd1, 16'd0);
    idle(2);
    a = count_o; idle(8);
    chk("R1 prescale 0", count_o - a, 16'd8);
    wr(4'd0, 16'h0);
    idle(2);
    a = count_o; idle(10);
    chk("R1 halted", count_o, a);
  endtask

  task automatic t_event;
    wr(4'd9, 16'h0100);
    wr(4'd0, 16'h3);
    epulse(5);
    chk("R2 event count", count_o, 16'h0105);
    wr(4'd0, 16'h2);
    epulse(2);
    chk("R2 stopped", count_o, 16'h0105);
  endtask

  task automatic t_overflow;
    wr(4'd0, 16'h3);
    wr(4'd9, 16'hFFFE);
    wr(4'd8, 16'hFFFF);
    epulse(1);
    chk("R3 at FFFF", count_o, 16'hFFFF);
    chk("R3 no flag yet", flags_o[7], 1'b0);
    epulse(1);
    chk("R3 wrap", count_o, 16'h0000);
    chk("R3 overflow flag", flags_o[7], 1'b1);
  endtask

  task automatic t_clear;
    wr(4'd9, 16'h0055);
    clr_pin = 1'b1; idle(6);
    chk("R4 clear", count_o, 16'h0);
    epulse(1);
    chk("R4 level no hold", count_o, 16'h1);
    clr_pin = 1'b0; idle(4);
  endtask

  task automatic t_capture;
    wr(4'd0, 16'h2);
    wr(4'd2, 16'h0039);
    wr(4'd8, 16'hFFFF);
    wr(4'd9, 16'h1111);
    cap_pin = 4'hF; idle(6);
    chk("R5 rise", cap_o, {16'h0, 16'h1111, 16'h0, 16'h1111});
    chk("R5 rise flags", flags_o[3:0], 4'b0101);
    wr(4'd9, 16'h2222);
    cap_pin = 4'h0; idle(6);
    chk("R5 fall", cap_o, {16'h0, 16'h2222, 16'h2222, 16'h1111});
    chk("R5 fall flags", flags_o[3:0], 4'b0111);
  endtask

  task automatic t_flags;
    wr(4'd8, 16'h0002);
    chk("R10 partial clear", flags_o[3:0], 4'b0101);
    wr(4'd8, 16'h00FF);
    chk("R10 full clear", {irq_o, flags_o}, 9'h0);
  endtask

  task automatic t_set;
    wr(4'd3, 16'h0010);
    wr(4'd6, 16'h00FF);
    wr(4'd0, 16'h3);
    wr(4'd9, 16'h000E);
    wr(4'd8, 16'hFFFF);
    epulse(1);
    chk("R6 before match", pins_o, 8'h00);
    epulse(1);
    chk("R6 R9 set", pins_o, 8'h3F);
    chk("R6 flag", flags_o[4], 1'b1);
  endtask

  task automatic t_reset_cmp;
    wr(4'd4, 16'h0012);
    wr(4'd6, 16'hC500);
    wr(4'd9, 16'h0011);
    wr(4'd8, 16'hFFFF);
    epulse(1);
    chk("R7 R9 reset", pins_o, 8'h3A);
    chk("R7 flag", flags_o[5], 1'b1);
    wr(4'd3, 16'h0020);
    wr(4'd4, 16'h0020);
    wr(4'd6, 16'h0203);
    wr(4'd9, 16'h001F);
    epulse(1);
    chk("R7 reset wins", pins_o, 8'h39);
  endtask

  task automatic t_toggle;
    wr(4'd5, 16'h0030);
    wr(4'd7, 16'h00FF);
    wr(4'd9, 16'h002F);
    wr(4'd8, 16'hFFFF);
    epulse(1);
    chk("R8 R9 toggle", pins_o, 8'hF9);
    chk("R8 flag", flags_o[6], 1'b1);
    wr(4'd7, 16'h0040);
    wr(4'd9, 16'h002F);
    epulse(1);
    chk("R8 one pin", pins_o, 8'hB9);
  endtask

  task automatic t_load;
    wr(4'd8, 16'hFFFF);
    wr(4'd9, 16'h0030);
    idle(4);
    chk("R12 loaded", count_o, 16'h0030);
    chk("R12 no match pins", pins_o, 8'hB9);
    chk("R12 no match flag", flags_o[6], 1'b0);
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_prescale();
    t_event();
    t_overflow();
    t_clear();
    t_capture();
    t_flags();
    t_set();
    t_reset_cmp();
    t_toggle();
    t_load();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule